// File: doc/BRIEF.md
# Programmable Clock Post-Divider and Output Router

This block forms the digital back end of a programmable clock generator. It receives a reference clock and a synthesizer clock. Both arrive as ordinary level inputs, and the block samples them on its own system clock. An even post-divider divides one of them by twice a 14-bit setting. The block then steers one of several sources to a main clock output. A secondary output can carry the reference, half the reference, the main output, or half the main output.

Two complete configuration sets are held on input ports, and a select input chooses between them while the block runs. A new set is applied only when the divided clock is about to start a fresh period, so no shortened phase appears on the output. Output-enable and power-down inputs control an enable flag beside each clock, and that flag stands for the output's high-impedance state. Power-down also clears and holds every counter. After power-down is released, both outputs stay disabled until one full divided period has passed. A configuration bit decides whether the shared secondary pin is driven as a clock at all.

Top module: `clkdiv_router`

## Requirements
- R1: The divided clock changes level only on rising edges of its source. It stays high for p_eff source periods and low for p_eff source periods, so its period is 2*p_eff source periods with 50% duty.
- R2: A post-divider setting of 0 acts as 1, so the divided clock has a period of 2 source periods.
- R3: The main source select, a_c0_sel or b_c0_sel, is decoded as follows: 0 gives the synthesizer clock divided by 2*P; 1 gives the undivided reference; 2 gives the reference divided by 2*P; 3 behaves like 0.
- R4: The secondary source select, a_c1_sel or b_c1_sel, is decoded as follows: 0 gives the reference; 1 gives the reference divided by 2; 2 gives the main output; 3 gives the main output divided by 2. Each of these has 50% duty.
- R5: When oe is 0, clk0_en and clk1_en are both 0.
- R6: From the cycle after pdb_n is seen low, clk0, clk1, clk0_en and clk1_en are all 0, and every divider counter is cleared.
- R7: After pdb_n returns to 1, clk0_en stays 0 until the divided clock has completed one full period from zero.
- R8: When fsel is 0, set A is selected; when fsel is 1, set B is selected. A change of selection takes effect only at a high-to-low transition of the divided clock, during power-down, or during reset. Every phase on clk0 is therefore a full phase of either the old set or the new set.
- R9: When clk1_pin_en is 0, clk1_en is 0 and clk1 is held low.
- R10: While rst is high, clk0_en and clk1_en read 0 and clk0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock level |
| pll_in | input | 1 | Synthesizer clock level |
| oe | input | 1 | Output enable, active high |
| pdb_n | input | 1 | Power-down, active low |
| fsel | input | 1 | Configuration set select (0 = A, 1 = B) |
| a_p | input | 14 | Set A post-divider value |
| a_c0_sel | input | 2 | Set A main source select |
| a_c1_sel | input | 2 | Set A secondary source select |
| b_p | input | 14 | Set B post-divider value |
| b_c0_sel | input | 2 | Set B main source select |
| b_c1_sel | input | 2 | Set B secondary source select |
| clk1_pin_en | input | 1 | Drive the shared pin as the secondary clock |
| clk0 | output | 1 | Main clock |
| clk0_en | output | 1 | Main clock driven (0 = high impedance) |
| clk1 | output | 1 | Secondary clock |
| clk1_en | output | 1 | Secondary clock driven (0 = high impedance) |

## Verification
The bench measures period and high time on both outputs for seven source and divider combinations, including a divider setting of 0 and the reserved main select. A design that counted to P instead of P-1 would fail these checks, and so would one with a lopsided duty cycle. It switches fsel while clk0 is in mid-phase and checks every phase that follows. A design that applied the new set immediately would produce a phase matching neither divider. The bench also checks that the enables stay low for most of the first period after power-down is released, walks all four oe and pdb_n combinations, and confirms that the secondary pin stays dark when it is not configured as a clock.

// File: rtl/ckr_pkg.sv
package ckr_pkg;

    localparam int P_W   = 14;
    localparam int SEL_W = 2;
    localparam int N_HALF = 2;

    typedef enum logic [SEL_W-1:0] {
        C0_PLL_DIV = 2'd0,
        C0_REF     = 2'd1,
        C0_REF_DIV = 2'd2,
        C0_RSVD    = 2'd3
    } c0_src_e;

    typedef enum logic [SEL_W-1:0] {
        C1_REF       = 2'd0,
        C1_REF_HALF  = 2'd1,
        C1_MAIN      = 2'd2,
        C1_MAIN_HALF = 2'd3
    } c1_src_e;

    typedef struct packed {
        logic [P_W-1:0] p;
        c0_src_e        c0;
        c1_src_e        c1;
    } cfg_t;

    function automatic logic [P_W-1:0] eff_p(input logic [P_W-1:0] p);
        return (p == '0) ? P_W'(1) : p;
    endfunction

    function automatic logic uses_ref(input c0_src_e s);
        return (s == C0_REF) || (s == C0_REF_DIV);
    endfunction

endpackage

// File: rtl/ckr_post_div.sv
module ckr_post_div #(
    parameter int PW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [PW-1:0] p_eff,
    output logic          div_o,
    output logic          fall_o
);
    logic [PW-1:0] cnt;
    logic          last;

    assign last   = (cnt == p_eff - PW'(1));
    assign fall_o = tick && last && div_o;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt   <= '0;
            div_o <= 1'b0;
        end else if (tick) begin
            if (last) begin
                cnt   <= '0;
                div_o <= ~div_o;
            end else begin
                cnt <= cnt + PW'(1);
            end
        end
    end
endmodule

// File: rtl/ckr_half_div.sv
module ckr_half_div (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst || clr) q_o <= 1'b0;
        else if (tick)  q_o <= ~q_o;
    end
endmodule

// File: rtl/clkdiv_router.sv
module clkdiv_router
    import ckr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             pll_in,
    input  logic             oe,
    input  logic             pdb_n,
    input  logic             fsel,
    input  logic [13:0]      a_p,
    input  logic [1:0]       a_c0_sel,
    input  logic [1:0]       a_c1_sel,
    input  logic [13:0]      b_p,
    input  logic [1:0]       b_c0_sel,
    input  logic [1:0]       b_c1_sel,
    input  logic             clk1_pin_en,
    output logic             clk0,
    output logic             clk0_en,
    output logic             clk1,
    output logic             clk1_en
);
    cfg_t cfg_a, cfg_b, sel_cfg, act;

    assign cfg_a   = '{p: a_p, c0: c0_src_e'(a_c0_sel), c1: c1_src_e'(a_c1_sel)};
    assign cfg_b   = '{p: b_p, c0: c0_src_e'(b_c0_sel), c1: c1_src_e'(b_c1_sel)};
    assign sel_cfg = fsel ? cfg_b : cfg_a;

    logic ref_q, pll_q, c0_q, pwr_q, warm;
    logic ref_tick, pll_tick, div_tick, c0_tick;
    logic div, div_fall, c0_lvl, c1_lvl;
    logic [P_W-1:0] p_eff;
    logic [N_HALF-1:0] half_tick, half_q;

    assign ref_tick = ref_in & ~ref_q;
    assign pll_tick = pll_in & ~pll_q;
    assign div_tick = uses_ref(act.c0) ? ref_tick : pll_tick;
    assign p_eff    = eff_p(act.p);

    // state: sampled levels, power flag, warm-up flag, active set
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
            pll_q <= 1'b0;
            c0_q  <= 1'b0;
            pwr_q <= 1'b0;
            warm  <= 1'b0;
            act   <= sel_cfg;
        end else begin
            ref_q <= ref_in;
            pll_q <= pll_in;
            c0_q  <= c0_lvl;
            pwr_q <= pdb_n;
            if (!pdb_n) begin
                warm <= 1'b0;
                act  <= sel_cfg;
            end else if (div_fall) begin
                warm <= 1'b1;
                act  <= sel_cfg;
            end
        end
    end

    ckr_post_div #(.PW(P_W)) u_post (
        .clk    (clk),
        .rst    (rst),
        .clr    (!pdb_n),
        .tick   (div_tick),
        .p_eff  (p_eff),
        .div_o  (div),
        .fall_o (div_fall)
    );

    assign c0_lvl  = (act.c0 == C0_REF) ? ref_q : div;
    assign c0_tick = c0_lvl & ~c0_q;

    assign half_tick[0] = ref_tick;
    assign half_tick[1] = c0_tick;

    for (genvar i = 0; i < N_HALF; i++) begin : g_half
        ckr_half_div u_half (
            .clk  (clk),
            .rst  (rst),
            .clr  (!pdb_n),
            .tick (half_tick[i]),
            .q_o  (half_q[i])
        );
    end

    always_comb begin
        unique case (act.c1)
            C1_REF:       c1_lvl = ref_q;
            C1_REF_HALF:  c1_lvl = half_q[0];
            C1_MAIN:      c1_lvl = c0_lvl;
            C1_MAIN_HALF: c1_lvl = half_q[1];
            default:      c1_lvl = 1'b0;
        endcase
    end

    assign clk0    = pwr_q & c0_lvl;
    assign clk1    = pwr_q & clk1_pin_en & c1_lvl;
    assign clk0_en = oe & pdb_n & warm;
    assign clk1_en = clk0_en & clk1_pin_en;

endmodule

// File: rtl/clkdiv_router_chk.sv
module clkdiv_router_chk
    import ckr_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic pdb_n,
    input logic clk0,
    input logic clk1,
    input logic clk0_en,
    input logic clk1_en,
    input logic clk1_pin_en,
    input cfg_t act,
    input logic div,
    input logic div_fall,
    input logic div_tick
);
    // R6
    pd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pdb_n |=> (!clk0 && !clk1 && !clk0_en && !clk1_en));

    // R7
    wake_dark_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pdb_n) |=> !clk0_en);

    // R8
    cfg_swap_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(act) |-> ($past(div_fall) || !$past(pdb_n) || $past(rst)));

    // R1
    div_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(div) |-> ($past(div_tick) || !$past(pdb_n) || $past(rst)));

    // R9
    pin_off_chk: assert property (@(posedge clk) disable iff (rst)
        !clk1_pin_en |-> (!clk1_en && !clk1));
endmodule

bind clkdiv_router clkdiv_router_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pdb_n       (pdb_n),
    .clk0        (clk0),
    .clk1        (clk1),
    .clk0_en     (clk0_en),
    .clk1_en     (clk1_en),
    .clk1_pin_en (clk1_pin_en),
    .act         (act),
    .div         (div),
    .div_fall    (div_fall),
    .div_tick    (div_tick)
);

// File: tb/clkdiv_router_tb.sv
module clkdiv_router_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_in = 1'b0, pll_in = 1'b0;
    logic        oe = 1'b1, pdb_n = 1'b1, fsel = 1'b0;
    logic [13:0] a_p = 14'd1, b_p = 14'd1;
    logic [1:0]  a_c0_sel = 2'd0, a_c1_sel = 2'd0, b_c0_sel = 2'd0, b_c1_sel = 2'd0;
    logic        clk1_pin_en = 1'b1;
    logic        clk0, clk0_en, clk1, clk1_en;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;   // 250 MHz

    clkdiv_router u_dut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .pll_in(pll_in),
        .oe(oe), .pdb_n(pdb_n), .fsel(fsel),
        .a_p(a_p), .a_c0_sel(a_c0_sel), .a_c1_sel(a_c1_sel),
        .b_p(b_p), .b_c0_sel(b_c0_sel), .b_c1_sel(b_c1_sel),
        .clk1_pin_en(clk1_pin_en),
        .clk0(clk0), .clk0_en(clk0_en), .clk1(clk1), .clk1_en(clk1_en)
    );

    // reference: period 6 cycles, synthesizer: period 4 cycles
    int rcnt = 0;
    int pcnt = 0;
    always @(negedge clk) begin
        rcnt <= (rcnt == 2) ? 0 : rcnt + 1;
        if (rcnt == 2) ref_in <= ~ref_in;
        pcnt <= (pcnt == 1) ? 0 : pcnt + 1;
        if (pcnt == 1) pll_in <= ~pll_in;
    end

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct packed {
        logic [13:0] p;
        logic [1:0]  c0;
        logic [1:0]  c1;
        logic [15:0] e0;
        logic [15:0] e1;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{14'd3, 2'd0, 2'd0, 16'd24, 16'd6},
        '{14'd1, 2'd1, 2'd1, 16'd6,  16'd12},
        '{14'd2, 2'd2, 2'd2, 16'd24, 16'd24},
        '{14'd5, 2'd0, 2'd3, 16'd40, 16'd80},
        '{14'd0, 2'd0, 2'd2, 16'd8,  16'd8},
        '{14'd4, 2'd2, 2'd3, 16'd48, 16'd96},
        '{14'd2, 2'd3, 2'd0, 16'd16, 16'd6}
    };

    task automatic chk(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic logic smp(input bit which);
        return which ? clk1 : clk0;
    endfunction

    task automatic wait_lvl(input bit which, input bit want);
        logic prev, cur;
        prev = smp(which);
        forever begin
            @(negedge clk);
            cur = smp(which);
            if (cur == want && prev != want) return;
            prev = cur;
        end
    endtask

    task automatic wait_toggle(input bit which);
        logic prev;
        prev = smp(which);
        forever begin
            @(negedge clk);
            if (smp(which) != prev) return;
        end
    endtask

    task automatic meas(input bit which, output int per, output int hi);
        int t0, t1;
        wait_lvl(which, 1'b1);
        wait_lvl(which, 1'b1);
        t0 = cyc;
        wait_lvl(which, 1'b0);
        t1 = cyc;
        wait_lvl(which, 1'b1);
        per = cyc - t0;
        hi  = t1 - t0;
    endtask

    task automatic wait_en();
        while (!clk0_en) @(negedge clk);
    endtask

    task automatic apply_a(input logic [13:0] p, input logic [1:0] c0, input logic [1:0] c1);
        @(negedge clk);
        a_p = p; a_c0_sel = c0; a_c1_sel = c1; fsel = 1'b0; pdb_n = 1'b0;
        repeat (3) @(negedge clk);
        pdb_n = 1'b1;
        wait_en();
    endtask

    initial begin
        int per, hi, t0, len;
        bit ok, seen;
        // R10: reset state
        repeat (4) @(negedge clk);
        chk("R10 clk0_en in reset", clk0_en, 0);
        chk("R10 clk1_en in reset", clk1_en, 0);
        chk("R10 clk0 in reset", clk0, 0);
        rst = 1'b0;

        // vector table: R1 R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            apply_a(VEC[i].p, VEC[i].c0, VEC[i].c1);
            meas(1'b0, per, hi);
            chk($sformatf("R1/R3 clk0 period vec%0d", i), per, int'(VEC[i].e0));
            chk($sformatf("R1 clk0 high time vec%0d", i), hi, int'(VEC[i].e0) / 2);
            meas(1'b1, per, hi);
            chk($sformatf("R4 clk1 period vec%0d", i), per, int'(VEC[i].e1));
            chk($sformatf("R4 clk1 high time vec%0d", i), hi, int'(VEC[i].e1) / 2);
        end

        // R5 / R6: output enable and power-down combinations
        apply_a(14'd3, 2'd0, 2'd0);
        @(negedge clk); oe = 1'b1; pdb_n = 1'b1;
        @(negedge clk);
        chk("R5 oe=1 pdb=1 clk0_en", clk0_en, 1);
        chk("R5 oe=1 pdb=1 clk1_en", clk1_en, 1);
        oe = 1'b0;
        @(negedge clk);
        chk("R5 oe=0 pdb=1 clk0_en", clk0_en, 0);
        chk("R5 oe=0 pdb=1 clk1_en", clk1_en, 0);
        oe = 1'b1; pdb_n = 1'b0;
        @(negedge clk);
        chk("R6 oe=1 pdb=0 clk0_en", clk0_en, 0);
        chk("R6 oe=1 pdb=0 clk1_en", clk1_en, 0);
        oe = 1'b0;
        @(negedge clk);
        chk("R6 oe=0 pdb=0 clk0_en", clk0_en, 0);
        chk("R6 oe=0 pdb=0 clk1_en", clk1_en, 0);
        seen = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (clk0 || clk1) seen = 1'b1;
        end
        chk("R6 clocks held low in power-down", int'(seen), 0);
        oe = 1'b1;

        // R7: release, enables stay low through most of the first period
        pdb_n = 1'b1;
        repeat (14) @(negedge clk);
        chk("R7 clk0_en low early after release", clk0_en, 0);
        ok = 1'b0;
        for (int k = 0; k < 30; k++) begin
            if (clk0_en) ok = 1'b1;
            @(negedge clk);
        end
        chk("R7 clk0_en rises after first period", int'(ok), 1);

        // R9: secondary pin not a clock
        clk1_pin_en = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (clk1 || clk1_en) seen = 1'b1;
        end
        chk("R9 clk1 dark when pin is input", int'(seen), 0);
        chk("R9 clk0_en unaffected", clk0_en, 1);
        clk1_pin_en = 1'b1;

        // R8: on-the-fly switch A (P=3) -> B (P=5), synthesizer source
        b_p = 14'd5; b_c0_sel = 2'd0; b_c1_sel = 2'd0;
        wait_lvl(1'b0, 1'b1);
        repeat (5) @(negedge clk);      // mid high phase
        fsel = 1'b1;
        wait_toggle(1'b0);
        t0 = cyc;
        ok = 1'b1;
        for (int k = 0; k < 6; k++) begin
            wait_toggle(1'b0);
            len = cyc - t0;
            t0  = cyc;
            if (len != 12 && len != 20) ok = 1'b0;
        end
        chk("R8 no runt phase across switch", int'(ok), 1);
        meas(1'b0, per, hi);
        chk("R8 set B period after switch", per, 40);
        fsel = 1'b0;
        meas(1'b0, per, hi);
        meas(1'b0, per, hi);
        chk("R8 set A period after switch back", per, 24);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule